// File: doc/BRIEF.md
# Maintain-Power Signature and Sleep Controller

This controller sits in the digital core of a powered device on a power-over-cable port. Once the input isolation switch is fully on, it watches a periodically sampled port-current comparator. When the load stays light for long enough, it switches on a pulsed keep-alive current so that the supply side does not disconnect the port. It also accepts sleep requests from two control pins and leaves sleep on a wake pin. It drives an LED pulse enable and a power-good output that keeps the downstream converter off whenever that converter must not run.

All timing comes from two strobes that the caller supplies. `tick_smp` is the comparator sample strobe, nominally every 32 µs. `tick_ms` is a 1 ms time base. The pulsed keep-alive current uses an 84-tick period. Its on-time is 25 % by default. When the automatic power-class mode is active, a 2-bit strap selects a shorter on-time. Sleep is requested either on the falling edge of the sleep pin or, in a variant chosen by parameter, only after that pin has stayed low for a programmable number of ticks.

Top module: `mps_sleep_ctrl`

## Requirements
- R1: After reset, and until `fet_on` is high, `state` is 0 and `pg`, `mps_en` and `led_en` are low. With `fet_on` high and `tsd` low, the block moves to normal mode (`state` = 1) and `pg` goes high.
- R2: In normal mode, the block enters keep-alive mode (`state` = 2) only after RUN_LEN (10) consecutive `tick_smp` samples with `cmp_low` = 1. A sample with `cmp_low` = 0 restarts the count. A run of low samples has no effect in either sleep mode.
- R3: After entering keep-alive mode, the comparator is ignored for HOLD_TICKS (84) `tick_ms` ticks. After that, a sample with `cmp_low` = 0 returns the block to normal mode.
- R4: In keep-alive mode, `mps_en` repeats with a period of MPS_PERIOD (84) `tick_ms` ticks. Its on-time is 21 ticks (25 %) when `acls_act` = 0. When `acls_act` = 1, `acls_sel` selects the on-time: 00 gives 4 ticks (5 %), 01 gives 8 ticks (10 %), 10 gives 13 ticks (15 %) and 11 gives 21 ticks (25 %).
- R5: In keep-alive mode and in both sleep modes, `led_en` is high for 1 of every 4 `tick_ms` ticks. In normal mode and off mode, `led_en` is low.
- R6: In keep-alive mode, `pg` stays high, and falling edges on the sleep pin or the wake pin leave `state` at 2.
- R7: In normal mode, a sleep request enters sleep (`state` = 3) if the synchronised `ulp_pin` is high, or ultra-low-power sleep (`state` = 4) if it is low. In both sleep modes `pg` is low and `mps_en` runs the 25 % pattern.
- R8: In either sleep mode, a falling edge on `wk_pin` returns the block to normal mode with `pg` high.
- R9: With SL_HOLD_EN = 1, a sleep request is raised only after `sl_pin` has stayed low for SL_HOLD_TICKS (6000) ticks following its falling edge. A shorter low pulse requests nothing.
- R10: From any mode, `tsd` = 1 or `fet_on` = 0 forces `state` to 0 at the next clock edge, with all three outputs low. Clearing the condition returns the block to normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_smp | input | 1 | Comparator sample strobe, one cycle wide |
| tick_ms | input | 1 | Millisecond time-base strobe, one cycle wide |
| cmp_low | input | 1 | Port current below the keep-alive threshold |
| fet_on | input | 1 | Isolation switch fully on |
| tsd | input | 1 | Thermal shutdown active |
| sl_pin | input | 1 | Sleep request pin, asynchronous |
| wk_pin | input | 1 | Wake pin, asynchronous, active on its falling edge |
| ulp_pin | input | 1 | Ultra-low-power select, asynchronous, reads high after reset |
| acls_act | input | 1 | Automatic power-class mode active |
| acls_sel | input | 2 | Keep-alive duty select, used when `acls_act` is high |
| mps_en | output | 1 | Pulsed keep-alive current enable |
| led_en | output | 1 | LED pulse enable |
| pg | output | 1 | Power good |
| state | output | 3 | Mode code: 0 off, 1 normal, 2 keep-alive, 3 sleep, 4 ultra-low-power sleep |

## Verification
A wrong mode register appears on `state` and `pg` at the first clock edge after the triggering input. Pin-driven transitions take three edges because of the synchronisers. A miscounted sample run changes the cycle in which `state` becomes 2, and the bench detects this by counting whole sample windows. A wrong duty select or a wrong period shows up as a wrong count of `mps_en` or `led_en` cycles, measured over one full period of that output. A broken hold timer lets `state` drop back to 1 before HOLD_TICKS ticks have passed.

// File: rtl/mpsc_pkg.sv
package mpsc_pkg;

   typedef enum logic [2:0] {
      ST_OFF  = 3'd0,
      ST_NORM = 3'd1,
      ST_MPS  = 3'd2,
      ST_SLP  = 3'd3,
      ST_ULP  = 3'd4
   } mpsc_state_e;

   // On-time in ticks for a percentage of a period, rounded to nearest
   function automatic int unsigned pct_ticks(input int unsigned period,
                                             input int unsigned pct);
      return (period * pct + 50) / 100;
   endfunction

endpackage

// File: rtl/mpsc_sync.sv
module mpsc_sync #(
   parameter int unsigned      WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] meta_q;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("mpsc_sync: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= RST_VAL;
         q      <= RST_VAL;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/mpsc_pwm.sv
module mpsc_pwm #(
   parameter int unsigned PERIOD = 84,
   localparam int unsigned CW    = $clog2(PERIOD + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          tick,
   input  logic [CW-1:0] on_cnt,
   output logic          pulse
);
   logic [CW-1:0] cnt_q;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("mpsc_pwm: PERIOD must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
      end
   end

   assign pulse = (cnt_q < on_cnt);

   // R4
   pwm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(PERIOD));

   // R4
   pwm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/mpsc_mps_det.sv
module mpsc_mps_det #(
   parameter int unsigned RUN_LEN    = 10,
   parameter int unsigned HOLD_TICKS = 84,
   localparam int unsigned RW        = $clog2(RUN_LEN),
   localparam int unsigned HW        = $clog2(HOLD_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic in_mps,
   input  logic tick_smp,
   input  logic cmp_low,
   input  logic tick_ms,
   output logic enter,
   output logic leave,
   output logic hold_done
);
   logic [RW-1:0] run_q;
   logic [HW-1:0] hold_q;

   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("mpsc_mps_det: RUN_LEN must be at least 2");
      end
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("mpsc_mps_det: HOLD_TICKS must be at least 1");
      end
   endgenerate

   // consecutive low-sample run, only while armed (normal mode)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!arm) begin
         run_q <= '0;
      end else if (tick_smp) begin
         if (!cmp_low)
            run_q <= '0;
         else if (run_q != RW'(RUN_LEN - 1))
            run_q <= run_q + 1'b1;
      end
   end

   assign enter = arm && tick_smp && cmp_low && (run_q == RW'(RUN_LEN - 1));

   // hold timer after entry, comparator ignored until it expires
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (!in_mps) begin
         hold_q <= '0;
      end else if (tick_ms && (hold_q != HW'(HOLD_TICKS))) begin
         hold_q <= hold_q + 1'b1;
      end
   end

   assign hold_done = (hold_q == HW'(HOLD_TICKS));
   assign leave     = in_mps && hold_done && tick_smp && !cmp_low;

   // R3
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mps && hold_done) |=> (!in_mps || hold_done));

   // R2
   run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && tick_smp && !cmp_low) |=> !enter || !arm || tick_smp == 1'b0 || RUN_LEN == 1);
endmodule

// File: rtl/mpsc_sleep_req.sv
module mpsc_sleep_req #(
   parameter bit          HOLD_EN    = 1'b0,
   parameter int unsigned HOLD_TICKS = 6000,
   localparam int unsigned TW        = $clog2(HOLD_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sl_s,
   input  logic tick,
   output logic req
);
   logic sl_d;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sl_d <= 1'b1;
      else        sl_d <= sl_s;
   end

   assign fall = sl_d && !sl_s;

   generate
      if (HOLD_EN == 1'b0) begin : g_edge
         assign req = fall;
      end else begin : g_hold
         logic          armed_q;
         logic [TW-1:0] cnt_q;
         logic          last;

         if (HOLD_TICKS < 1) begin : g_bad_hold
            $error("mpsc_sleep_req: HOLD_TICKS must be at least 1");
         end

         assign last = armed_q && !sl_s && tick && (cnt_q == TW'(HOLD_TICKS - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed_q <= 1'b0;
               cnt_q   <= '0;
            end else if (fall) begin
               armed_q <= 1'b1;
               cnt_q   <= '0;
            end else if (armed_q) begin
               if (sl_s || last)
                  armed_q <= 1'b0;
               else if (tick)
                  cnt_q <= cnt_q + 1'b1;
            end
         end

         assign req = last;

         // R9
         hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req |-> ($past(sl_s) == 1'b0));
      end
   endgenerate
endmodule

// File: rtl/mps_sleep_ctrl.sv
module mps_sleep_ctrl
   import mpsc_pkg::*;
#(
   parameter int unsigned RUN_LEN       = 10,
   parameter int unsigned HOLD_TICKS    = 84,
   parameter int unsigned MPS_PERIOD    = 84,
   parameter int unsigned LED_PERIOD    = 4,
   parameter int unsigned LED_ON        = 1,
   parameter bit          SL_HOLD_EN    = 1'b0,
   parameter int unsigned SL_HOLD_TICKS = 6000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_smp,
   input  logic       tick_ms,
   input  logic       cmp_low,
   input  logic       fet_on,
   input  logic       tsd,
   input  logic       sl_pin,
   input  logic       wk_pin,
   input  logic       ulp_pin,
   input  logic       acls_act,
   input  logic [1:0] acls_sel,
   output logic       mps_en,
   output logic       led_en,
   output logic       pg,
   output logic [2:0] state
);
   localparam int unsigned MCW    = $clog2(MPS_PERIOD + 1);
   localparam int unsigned LCW    = $clog2(LED_PERIOD + 1);
   localparam int unsigned ON_25  = pct_ticks(MPS_PERIOD, 25);
   localparam int unsigned ON_15  = pct_ticks(MPS_PERIOD, 15);
   localparam int unsigned ON_10  = pct_ticks(MPS_PERIOD, 10);
   localparam int unsigned ON_5   = pct_ticks(MPS_PERIOD, 5);

   generate
      if (LED_ON >= LED_PERIOD) begin : g_bad_led
         $error("mps_sleep_ctrl: LED_ON must be below LED_PERIOD");
      end
      if (ON_5 < 1) begin : g_bad_mps
         $error("mps_sleep_ctrl: MPS_PERIOD too short for a 5 percent on-time");
      end
   endgenerate

   // pin synchronisers; all three read high out of reset
   logic [2:0] pins_s;
   logic       sl_s, wk_s, ulp_s;

   mpsc_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sl_pin, wk_pin, ulp_pin}),
      .q     (pins_s)
   );
   assign {sl_s, wk_s, ulp_s} = pins_s;

   logic wk_d, wk_fall;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wk_d <= 1'b1;
      else        wk_d <= wk_s;
   end
   assign wk_fall = wk_d && !wk_s;

   logic slp_req;
   mpsc_sleep_req #(.HOLD_EN(SL_HOLD_EN), .HOLD_TICKS(SL_HOLD_TICKS)) u_slreq (
      .clk   (clk),
      .rst_n (rst_n),
      .sl_s  (sl_s),
      .tick  (tick_ms),
      .req   (slp_req)
   );

   mpsc_state_e st_q, st_nxt;
   logic        mps_enter, mps_leave, hold_done;

   mpsc_mps_det #(.RUN_LEN(RUN_LEN), .HOLD_TICKS(HOLD_TICKS)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (st_q == ST_NORM),
      .in_mps    (st_q == ST_MPS),
      .tick_smp  (tick_smp),
      .cmp_low   (cmp_low),
      .tick_ms   (tick_ms),
      .enter     (mps_enter),
      .leave     (mps_leave),
      .hold_done (hold_done)
   );

   // mode sequencing; keep-alive entry outranks a sleep request
   always_comb begin
      st_nxt = st_q;
      if (!fet_on || tsd) begin
         st_nxt = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF:  st_nxt = ST_NORM;
            ST_NORM: begin
               if (mps_enter)    st_nxt = ST_MPS;
               else if (slp_req) st_nxt = ulp_s ? ST_SLP : ST_ULP;
            end
            ST_MPS:  if (mps_leave) st_nxt = ST_NORM;
            ST_SLP,
            ST_ULP:  if (wk_fall) st_nxt = ST_NORM;
            default: st_nxt = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= st_nxt;
   end

   logic pulsing, restart;
   assign pulsing = (st_q == ST_MPS) || (st_q == ST_SLP) || (st_q == ST_ULP);
   assign restart = (st_nxt != st_q);

   // keep-alive on-time selection
   logic [MCW-1:0] mps_on;
   always_comb begin
      mps_on = MCW'(ON_25);
      if (st_q == ST_MPS && acls_act) begin
         unique case (acls_sel)
            2'b00: mps_on = MCW'(ON_5);
            2'b01: mps_on = MCW'(ON_10);
            2'b10: mps_on = MCW'(ON_15);
            2'b11: mps_on = MCW'(ON_25);
            default: mps_on = MCW'(ON_25);
         endcase
      end
   end

   logic mps_pulse, led_pulse;

   mpsc_pwm #(.PERIOD(MPS_PERIOD)) u_mps_pwm (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick_ms),
      .on_cnt  (mps_on),
      .pulse   (mps_pulse)
   );

   mpsc_pwm #(.PERIOD(LED_PERIOD)) u_led_pwm (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick_ms),
      .on_cnt  (LCW'(LED_ON)),
      .pulse   (led_pulse)
   );

   assign mps_en = pulsing && mps_pulse;
   assign led_en = pulsing && led_pulse;
   assign pg     = (st_q == ST_NORM) || (st_q == ST_MPS);
   assign state  = st_q;

   // R2
   mps_from_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MPS && $past(st_q) != ST_MPS) |-> ($past(st_q) == ST_NORM));

   // R6
   mps_no_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MPS && fet_on && !tsd) |=> (st_q == ST_MPS || st_q == ST_NORM));

   // R3
   hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MPS && !hold_done) |=> (st_q != ST_NORM));

   // R10
   force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fet_on || tsd) |=> (state == 3'd0 && !pg && !led_en && !mps_en));

   // R8
   wake_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_SLP || st_q == ST_ULP) && !wk_fall && fet_on && !tsd) |=> $stable(st_q));
endmodule

// File: tb/tb_mps_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_mps_sleep_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_smp = 1'b0, tick_ms = 1'b0;
   logic       cmp_low = 1'b0, fet_on = 1'b0, tsd = 1'b0;
   logic       sl_pin = 1'b1, wk_pin = 1'b1, ulp_pin = 1'b1;
   logic       acls_act = 1'b0;
   logic [1:0] acls_sel = 2'b00;
   logic       mps_en, led_en, pg;
   logic [2:0] state;
   logic       mps_en_h, led_en_h, pg_h;
   logic [2:0] state_h;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mps_sleep_ctrl dut (
      .clk(clk), .rst_n(rst_n), .tick_smp(tick_smp), .tick_ms(tick_ms),
      .cmp_low(cmp_low), .fet_on(fet_on), .tsd(tsd), .sl_pin(sl_pin),
      .wk_pin(wk_pin), .ulp_pin(ulp_pin), .acls_act(acls_act),
      .acls_sel(acls_sel), .mps_en(mps_en), .led_en(led_en), .pg(pg),
      .state(state));

   mps_sleep_ctrl #(.SL_HOLD_EN(1'b1)) dut_h (
      .clk(clk), .rst_n(rst_n), .tick_smp(tick_smp), .tick_ms(tick_ms),
      .cmp_low(cmp_low), .fet_on(fet_on), .tsd(tsd), .sl_pin(sl_pin),
      .wk_pin(wk_pin), .ulp_pin(ulp_pin), .acls_act(acls_act),
      .acls_sel(acls_sel), .mps_en(mps_en_h), .led_en(led_en_h), .pg(pg_h),
      .state(state_h));

   // acls_act, acls_sel, expected mps_en high cycles per 84-tick period (4 clk/tick)
   localparam int VEC [5][3] = '{
      '{0, 0, 84}, '{1, 0, 16}, '{1, 1, 32}, '{1, 2, 52}, '{1, 3, 84}};

   // time bases: tick_ms every 4 cycles, tick_smp every 8 cycles
   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc++;
         tick_ms  = (tc % 4 == 0);
         tick_smp = (tc % 8 == 0);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // each 8-cycle window holds exactly one sample strobe
   task automatic samples(input int n, input logic v);
      cmp_low = v;
      repeat (n) wait_cyc(8);
   endtask

   task automatic count_hi(input int n, input bit led, output int c);
      c = 0;
      repeat (n) begin
         @(negedge clk);
         if (led ? led_en : mps_en) c++;
      end
   endtask

   task automatic pin_fall(input int which);
      if (which == 0) sl_pin = 1'b0; else wk_pin = 1'b0;
      wait_cyc(10);
      if (which == 0) sl_pin = 1'b1; else wk_pin = 1'b1;
      wait_cyc(5);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int c;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);
      // R1 reset / switch not yet on
      check("R1 state", state, 0);
      check("R1 pg", pg, 0);
      check("R1 mps_en", mps_en, 0);
      check("R1 led_en", led_en, 0);
      fet_on = 1'b1;
      wait_cyc(3);
      check("R1 normal", state, 1);
      check("R1 pg high", pg, 1);
      check("R5 led off normal", led_en, 0);

      // R2 nine lows then a high: no entry; then ten lows: entry
      samples(9, 1'b1);
      samples(1, 1'b0);
      check("R2 short run", state, 1);
      samples(10, 1'b1);
      check("R2 entry", state, 2);

      // R6 pg high, pin edges ignored
      check("R6 pg", pg, 1);
      pin_fall(0);
      pin_fall(1);
      check("R6 sleep ignored", state, 2);
      count_hi(64, 1'b1, c);
      check("R5 led mps", c, 16);

      // R3 hold, then exit on a high sample
      cmp_low = 1'b0;
      wait_cyc(100);
      check("R3 held", state, 2);
      wait_cyc(200);
      check("R3 exit", state, 1);

      // R4 duty table
      for (int i = 0; i < 5; i++) begin
         acls_act = VEC[i][0][0];
         acls_sel = 2'(VEC[i][1]);
         samples(10, 1'b1);
         wait_cyc(4);
         count_hi(336, 1'b0, c);
         check($sformatf("R4 duty row %0d", i), c, VEC[i][2]);
         cmp_low = 1'b0;
         wait_cyc(400);
         check($sformatf("R4 exit row %0d", i), state, 1);
      end
      acls_act = 1'b1;
      acls_sel = 2'b00;

      // R7 sleep with ulp high; 25 % pattern regardless of select
      ulp_pin = 1'b1;
      pin_fall(0);
      check("R7 sleep", state, 3);
      check("R7 pg low", pg, 0);
      count_hi(336, 1'b0, c);
      check("R7 mps duty sleep", c, 84);
      count_hi(64, 1'b1, c);
      check("R5 led sleep", c, 16);
      pin_fall(0);
      check("R7 no re-request", state, 3);
      pin_fall(1);
      check("R8 wake", state, 1);
      check("R8 pg", pg, 1);

      // R7 ultra-low-power sleep
      ulp_pin = 1'b0;
      pin_fall(0);
      ulp_pin = 1'b1;
      check("R7 ulp sleep", state, 4);
      check("R7 ulp pg", pg, 0);
      samples(12, 1'b1);
      check("R2 no entry in sleep", state, 4);
      cmp_low = 1'b0;
      count_hi(64, 1'b1, c);
      check("R5 led ulp", c, 16);
      pin_fall(1);
      check("R8 wake ulp", state, 1);

      // R10 thermal shutdown from sleep
      pin_fall(0);
      check("R10 pre sleep", state, 3);
      tsd = 1'b1;
      wait_cyc(2);
      check("R10 tsd state", state, 0);
      check("R10 tsd pg", pg, 0);
      count_hi(32, 1'b1, c);
      check("R10 tsd led", c, 0);
      tsd = 1'b0;
      wait_cyc(3);
      check("R10 resume", state, 1);

      // R10 switch drop from keep-alive
      samples(10, 1'b1);
      check("R10 pre mps", state, 2);
      fet_on = 1'b0;
      wait_cyc(2);
      check("R10 fet state", state, 0);
      count_hi(340, 1'b0, c);
      check("R10 fet mps_en", c, 0);
      cmp_low = 1'b0;
      fet_on = 1'b1;
      wait_cyc(3);
      check("R10 fet resume", state, 1);

      // R9 hold variant
      check("R9 hold dut normal", state_h, 1);
      sl_pin = 1'b0;
      wait_cyc(100);
      sl_pin = 1'b1;
      wait_cyc(10);
      check("R9 edge dut sleeps", state, 3);
      check("R9 short pulse", state_h, 1);
      pin_fall(1);
      sl_pin = 1'b0;
      wait_cyc(23800);
      check("R9 before hold", state_h, 1);
      wait_cyc(600);
      check("R9 after hold", state_h, 3);
      sl_pin = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule